// File: doc/BRIEF.md
# Three-Mode 16-bit Timer/Counter

This block is a 16-bit up-counter with a byte-wide register interface. It holds a control register, the live count and a second 16-bit register that serves as either a capture latch or a reload value. The counter advances either on a one-cycle tick strobe that the surrounding logic derives from the oscillator divided by twelve (timer operation), or on falling edges of an external count pin (counter operation).

A separate trigger pin gives the block its modes. With capture selected, a falling edge on that pin latches the running count. With reload selected, the same edge restarts the count from the reload value, and every rollover also reloads it. When either baud-select bit is set, the block runs as a baud generator: reload is forced, the overflow flag stays quiet, trigger edges are ignored and each rollover emits a one-cycle pulse for a serial port. The overflow and trigger-event flags stay set until software clears them. While either flag is set, an interrupt request is raised.

Top module: `tri_mode_timer`

## Requirements
- R1: After a synchronous reset the control byte, the count and the capture/reload register all read 0x00, and ovf_flag, ext_flag, irq and baud_pulse are low.
- R2: With run (control bit 2) set and count-source select (bit 1) clear, the count advances by one on each clock with tick high and holds otherwise.
- R3: With bits 2 and 1 set, the count advances by one on each falling edge of cnt_pin, seen through a two-flop synchroniser (a 1 sample followed by a 0 sample), and tick has no effect.
- R4: With run clear, tick and cnt_pin do not change the count.
- R5: With capture select (bit 0) and trigger enable (bit 3) set and both baud selects clear, a falling edge on trig_pin copies the count into the capture/reload register and sets the event flag (bit 6).
- R6: In capture mode a step from 0xFFFF wraps the count to 0x0000 and sets the overflow flag (bit 7).
- R7: With bit 0 clear, a step from 0xFFFF loads the reload value into the count and sets the overflow flag.
- R8: With bit 0 clear and bit 3 set, a falling edge on trig_pin loads the reload value into the count and sets the event flag.
- R9: With bit 3 clear, trig_pin edges change neither the count, the capture/reload register nor the event flag.
- R10: When receive-baud select (bit 5) or transmit-baud select (bit 4) is set, bit 0 is ignored and rollover reloads the count. The overflow flag is not set. baud_pulse goes high for one cycle after each rollover, and trig_pin edges are ignored even with bit 3 set.
- R11: irq is high exactly when ovf_flag or ext_flag is set. Both flags hold until software writes them to 0.
- R12: A control write of 1 to a flag sets it. A write of 0 clears it, except when hardware sets that flag in the same cycle, in which case the flag ends at 1.
- R13: The address map is control at 0, count low/high at 1/2 and capture/reload low/high at 3/4. rd_data shows the register at addr one cycle later. A write to a count or capture/reload byte overrides any hardware update of that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled timebase strobe, one cycle wide |
| cnt_pin | input | 1 | External count input, asynchronous |
| trig_pin | input | 1 | External capture/reload trigger, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Overflow flag (control bit 7) |
| ext_flag | output | 1 | Trigger-event flag (control bit 6) |
| irq | output | 1 | Interrupt request |
| baud_pulse | output | 1 | One-cycle rollover pulse in baud mode |

## Verification
The bench builds the block with its default parameters: a 16-bit count split into two 8-bit bytes and a two-stage pin synchroniser. The count is preloaded through the register port to 0xFFFE or 0xFFFF, so wrap, reload and baud-pulse events can be reached within a few ticks instead of 65536. Because the synchroniser depth is kept at two, the pin-to-effect latency seen by the bench is three edges, which the reference model reproduces with a history of pin samples.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control byte bit positions (software decodes these)
  localparam int CTL_OVF = 7;
  localparam int CTL_EXT = 6;
  localparam int CTL_RXB = 5;
  localparam int CTL_TXB = 4;
  localparam int CTL_XEN = 3;
  localparam int CTL_RUN = 2;
  localparam int CTL_SRC = 1;
  localparam int CTL_CAP = 0;

  typedef struct packed {
    logic set_ovf;
    logic set_ext;
  } flag_set_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b1;
        else     sync_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sync_q[STAGES-1];
  end

  assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  flag_set_t         hw_set,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = wr_ctrl ? wr_data : ctrl_q;
    // a written 0 loses to a same-cycle hardware set
    ctrl_d[CTL_OVF] = ctrl_d[CTL_OVF] | hw_set.set_ovf;
    ctrl_d[CTL_EXT] = ctrl_d[CTL_EXT] | hw_set.set_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= ctrl_d[CTL_OVF] | ctrl_d[CTL_EXT];
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  localparam int N_BYTES = CNT_W / DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               load_hold,
  input  logic               grab_count,
  input  logic [N_BYTES-1:0] wr_cnt,
  input  logic [N_BYTES-1:0] wr_hold,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [CNT_W-1:0]   count_q,
  output logic [CNT_W-1:0]   hold_q,
  output logic               at_max
);
  logic [CNT_W-1:0] count_hw;

  assign at_max = &count_q;

  always_comb begin
    if (load_hold)  count_hw = hold_q;
    else if (step)  count_hw = count_q + CNT_W'(1);
    else            count_hw = count_q;
  end

  generate
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          count_q[b*DATA_W +: DATA_W] <= '0;
          hold_q[b*DATA_W +: DATA_W]  <= '0;
        end else begin
          if (wr_cnt[b]) count_q[b*DATA_W +: DATA_W] <= wr_data;
          else           count_q[b*DATA_W +: DATA_W] <= count_hw[b*DATA_W +: DATA_W];
          if (wr_hold[b])      hold_q[b*DATA_W +: DATA_W] <= wr_data;
          else if (grab_count) hold_q[b*DATA_W +: DATA_W] <= count_q[b*DATA_W +: DATA_W];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int N_BYTES = CNT_W / DATA_W,
  localparam int ADDR_W  = $clog2(2 * N_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq,
  output logic              baud_pulse
);
  logic [DATA_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]   count_q;
  logic [CNT_W-1:0]   hold_q;
  logic               at_max;
  logic               cnt_fall, trig_fall;
  logic               baud_mode, reload_mode, step, roll, trig_ev;
  logic [N_BYTES-1:0] wr_cnt, wr_hold;
  logic               wr_ctrl;
  flag_set_t          hw_set;
  logic [DATA_W-1:0]  rd_mux;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall));
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall));

  assign baud_mode   = ctrl_q[CTL_RXB] | ctrl_q[CTL_TXB];
  assign reload_mode = baud_mode | ~ctrl_q[CTL_CAP];
  assign step        = ctrl_q[CTL_RUN] & (ctrl_q[CTL_SRC] ? cnt_fall : tick);
  assign roll        = step & at_max;
  assign trig_ev     = trig_fall & ctrl_q[CTL_XEN] & ~baud_mode;

  assign hw_set.set_ovf = roll & ~baud_mode;
  assign hw_set.set_ext = trig_ev;

  assign wr_ctrl = wr_en && (addr == '0);
  generate
    for (genvar b = 0; b < N_BYTES; b++) begin : g_dec
      assign wr_cnt[b]  = wr_en && (addr == ADDR_W'(1 + b));
      assign wr_hold[b] = wr_en && (addr == ADDR_W'(1 + N_BYTES + b));
    end
  endgenerate

  tmr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .hw_set(hw_set), .ctrl_q(ctrl_q), .irq_q(irq));

  tmr_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .step(step),
    .load_hold((roll | trig_ev) & reload_mode),
    .grab_count(trig_ev & ~reload_mode),
    .wr_cnt(wr_cnt), .wr_hold(wr_hold), .wr_data(wr_data),
    .count_q(count_q), .hold_q(hold_q), .at_max(at_max));

  always_comb begin
    rd_mux = '0;
    if (addr == '0) rd_mux = ctrl_q;
    for (int b = 0; b < N_BYTES; b++) begin
      if (addr == ADDR_W'(1 + b))           rd_mux = count_q[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(1 + N_BYTES + b)) rd_mux = hold_q[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      baud_pulse <= 1'b0;
    end else begin
      rd_data    <= rd_mux;
      baud_pulse <= roll & baud_mode;
    end
  end

  assign ovf_flag = ctrl_q[CTL_OVF];
  assign ext_flag = ctrl_q[CTL_EXT];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int N_BYTES = CNT_W / DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctrl,
  input logic [CNT_W-1:0]  count,
  input logic              ovf_flag,
  input logic              ext_flag,
  input logic              irq,
  input logic              baud_pulse
);
  logic wr_ctrl, wr_count;
  assign wr_ctrl  = wr_en && (addr == '0);
  assign wr_count = wr_en && (addr != '0) && (addr <= ADDR_W'(N_BYTES));

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf_flag | ext_flag));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !wr_ctrl) |=> ovf_flag);

  assert_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[CTL_RUN] && !ctrl[CTL_XEN] && !wr_count) |=> $stable(count));

  assert_pulse_only_baud_R10: assert property (@(posedge clk) disable iff (rst)
    baud_pulse |-> $past(ctrl[CTL_RXB] | ctrl[CTL_TXB]));

  assert_no_ovf_baud_R10: assert property (@(posedge clk) disable iff (rst)
    (baud_pulse && !$past(wr_ctrl)) |-> ovf_flag == $past(ovf_flag));

  assert_ext_gated_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(ext_flag) && !$past(wr_ctrl && wr_data[CTL_EXT]))
      |-> ($past(ctrl[CTL_XEN]) && !$past(ctrl[CTL_RXB] | ctrl[CTL_TXB])));
endmodule

bind tri_mode_timer tmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .ctrl(ctrl_q), .count(count_q), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
  .irq(irq), .baud_pulse(baud_pulse));

// File: tb/tri_mode_timer_test.sv
`timescale 1ns/1ps
module tri_mode_timer_test;
  localparam int S = 2;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic ovf_flag, ext_flag, irq, baud_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  tri_mode_timer uut (.clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq),
    .baud_pulse(baud_pulse));

  always #2 clk = ~clk;

  // behavioural reference model
  int m_ctrl, m_cnt, m_hold, m_rd;
  bit m_irq, m_baud;
  bit cq[$], tq[$];

  function automatic int reg_value(int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt & 255;
      2: return m_cnt >> 8;
      3: return m_hold & 255;
      4: return m_hold >> 8;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_cnt = 0; m_hold = 0; m_rd = 0; m_irq = 0; m_baud = 0;
      cq.delete(); tq.delete();
      for (int i = 0; i <= S; i++) begin cq.push_back(1'b1); tq.push_back(1'b1); end
    end else begin
      bit fc, ft, baud, stp, roll, tev, rl, so, se;
      int nc, nh;
      fc = cq[S] && !cq[S-1];
      ft = tq[S] && !tq[S-1];
      cq.push_front(cnt_pin); void'(cq.pop_back());
      tq.push_front(trig_pin); void'(tq.pop_back());
      baud = m_ctrl[5] || m_ctrl[4];
      stp  = m_ctrl[2] && (m_ctrl[1] ? fc : tick);
      roll = stp && (m_cnt == 65535);
      tev  = ft && m_ctrl[3] && !baud;
      rl   = baud || !m_ctrl[0];
      m_rd = reg_value(int'(addr));
      if ((roll || tev) && rl) nc = m_hold;
      else if (stp)            nc = (m_cnt + 1) % 65536;
      else                     nc = m_cnt;
      nh = (tev && !rl) ? m_cnt : m_hold;
      if (wr_en && addr == 1) nc = (nc & 'hFF00) | wr_data;
      if (wr_en && addr == 2) nc = (nc & 'h00FF) | (int'(wr_data) << 8);
      if (wr_en && addr == 3) nh = (nh & 'hFF00) | wr_data;
      if (wr_en && addr == 4) nh = (nh & 'h00FF) | (int'(wr_data) << 8);
      so = roll && !baud;
      se = tev;
      if (wr_en && addr == 0) m_ctrl = wr_data;
      if (so) m_ctrl = m_ctrl | 'h80;
      if (se) m_ctrl = m_ctrl | 'h40;
      m_cnt = nc; m_hold = nh;
      m_baud = roll && baud;
      m_irq = m_ctrl[7] || m_ctrl[6];
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    check("R11 ovf_flag", int'(ovf_flag), int'(m_ctrl[7]));
    check("R5 ext_flag", int'(ext_flag), int'(m_ctrl[6]));
    check("R11 irq", int'(irq), int'(m_irq));
    check("R10 baud_pulse", int'(baud_pulse), int'(m_baud));
    check("R13 rd_data", int'(rd_data), m_rd);
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_expect(string req, int a, int exp);
    @(negedge clk); addr = 3'(a);
    @(negedge clk); check(req, int'(rd_data), exp);
  endtask

  task automatic set16(int a, int v);
    wr(a, v & 255); wr(a + 1, v >> 8);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic trig_fall();
    @(negedge clk); trig_pin = 1'b0;
    repeat (3) @(negedge clk);
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ovf", int'(ovf_flag), 0); check("R1 irq", int'(irq), 0);
    check("R1 baud", int'(baud_pulse), 0);
    rd_expect("R1 ctrl", 0, 'h00); rd_expect("R1 count", 1, 'h00);
    rd_expect("R1 hold", 4, 'h00);
    // R13 register map
    set16(3, 'h1234);
    rd_expect("R13 hold lo", 3, 'h34); rd_expect("R13 hold hi", 4, 'h12);
    // R2 timer mode
    set16(1, 'h0010); wr(0, 'h04);
    repeat (3) @(negedge clk);
    ticks(5); wr(0, 'h00);
    rd_expect("R2 count", 1, 'h15);
    // R4 stopped
    ticks(10);
    rd_expect("R4 count", 1, 'h15);
    // R3 counter mode, tick ignored
    wr(0, 'h06); tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cnt_pin = 1'b0; @(negedge clk); @(negedge clk); cnt_pin = 1'b1; @(negedge clk);
    end
    repeat (4) @(negedge clk);
    tick = 1'b0; wr(0, 'h00);
    rd_expect("R3 count", 1, 'h18);
    // R6 capture-mode wrap
    set16(1, 'hFFFE); wr(0, 'h05); ticks(2);
    rd_expect("R6 ctrl", 0, 'h85); rd_expect("R6 count lo", 1, 'h00);
    rd_expect("R6 count hi", 2, 'h00);
    check("R11 irq set", int'(irq), 1);
    repeat (3) @(negedge clk);
    check("R11 ovf holds", int'(ovf_flag), 1);
    // R12 clear by writing 0
    wr(0, 'h05);
    check("R12 cleared", int'(ovf_flag), 0); check("R11 irq clear", int'(irq), 0);
    // R5 capture
    wr(0, 'h0D); set16(1, 'h0100); trig_fall();
    rd_expect("R5 hold lo", 3, 'h00); rd_expect("R5 hold hi", 4, 'h01);
    rd_expect("R5 ctrl", 0, 'h4D);
    // R9 trigger disabled
    wr(0, 'h05); set16(3, 'hAAAA); trig_fall();
    rd_expect("R9 hold", 3, 'hAA); rd_expect("R9 ctrl", 0, 'h05);
    // R7 auto-reload on rollover
    wr(0, 'h00); set16(3, 'h1234); set16(1, 'hFFFF); wr(0, 'h04); ticks(1);
    rd_expect("R7 count lo", 1, 'h34); rd_expect("R7 count hi", 2, 'h12);
    rd_expect("R7 ctrl", 0, 'h84);
    // R8 trigger reload
    wr(0, 'h08); set16(1, 'h0050); trig_fall();
    rd_expect("R8 count lo", 1, 'h34); rd_expect("R8 ctrl", 0, 'h48);
    // R10 baud generation, receive select, capture bit ignored
    wr(0, 'h00); set16(3, 'hFFFE); set16(1, 'hFFFF); wr(0, 'h2D);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R10 pulse high", int'(baud_pulse), 1);
    @(negedge clk); check("R10 pulse low", int'(baud_pulse), 0);
    rd_expect("R10 reload", 1, 'hFE); rd_expect("R10 no ovf", 0, 'h2D);
    trig_fall();
    rd_expect("R10 trig ignored hold", 3, 'hFE); rd_expect("R10 trig ignored ctrl", 0, 'h2D);
    wr(0, 'h14); set16(1, 'hFFFF);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R10 tx pulse", int'(baud_pulse), 1);
    rd_expect("R10 tx ctrl", 0, 'h14);
    // R12 write 0 loses to same-cycle set; write 1 sets
    wr(0, 'h00); set16(3, 'h0000); set16(1, 'hFFFF); wr(0, 'h04);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wr_data = 8'h04;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd_expect("R12 race", 0, 'h84);
    wr(0, 'h04); rd_expect("R12 clear", 0, 'h04);
    wr(0, 'h84); rd_expect("R12 set by write", 0, 'h84);
    check("R11 irq by write", int'(irq), 1);
    // R13 write beats hardware step
    wr(0, 'h04);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 3'd1; wr_data = 8'h77;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    wr(0, 'h00);
    rd_expect("R13 write wins", 1, 'h77);
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule